// File: doc/BRIEF.md
# Serial audio port transceiver

This block is the slave end of a two-channel serial audio link carrying 16-bit samples. The bit clock, the frame clock and the serial data input all come from an external master. The block samples them with its own system clock and converts between the serial stream and parallel sample words. On the receive side it gathers the bits of one frame and presents a left word and a right word together with a one-cycle valid pulse. On the transmit side it holds one pending pair of words, taken through a ready/valid handshake. It loads that pair when a left half-frame begins and shifts it out MSB first on the bit clock's falling edges.

Frame clock high marks the left half and low marks the right half. The most significant bit sits in the first bit period after each frame clock transition. Two framings are accepted: 32 bit clocks per frame, with 16-bit halves, and 64 bit clocks per frame, where each 32-bit half holds 16 data bits and then 16 padding periods. The block counts bit clocks between left-half starts and reports whether a valid framing is present and which one it is.

Top module: `serial_audio_port`

## Requirements
- R1: Immediately after reset, `ser_dout` is 0, `rx_valid` is 0, `tx_ready` is 1 and `frame_lock` is 0.
- R2: On the rising edges of `bit_clk`, the first 16 bits after each `frame_clk` transition are captured MSB first as a two's complement word. The word belongs to the left channel when `frame_clk` is 1 and to the right channel when it is 0.
- R3: After the 16th bit of a right half whose left half in the same frame was captured, `rx_valid` pulses for exactly one system clock cycle. `rx_left` and `rx_right` carry that frame's words and do not change while `rx_valid` is 0.
- R4: Serial input bits past the 16th in a half-frame (the padding periods of the 64-bit framing) have no effect on the received words.
- R5: `ser_dout` changes only after falling edges of `bit_clk`. On the falling edge where `frame_clk` rises, the pending transmit pair is taken and its left word's MSB is driven. Each later falling edge drives the next lower bit. The right word is sent the same way starting at the falling edge where `frame_clk` falls.
- R6: From the 17th bit period of a half-frame to the end of that half, `ser_dout` is 0.
- R7: If no transmit pair is pending when a left half starts, both channels of that frame are sent as all zeros.
- R8: `tx_ready` is 1 exactly when no pair is pending. A pair is accepted on a clock cycle with `tx_valid` and `tx_ready` both 1, after which `tx_ready` is 0 until the next left half start takes the pair.
- R9: At each left half start, the number of `bit_clk` rising edges since the previous left half start is evaluated. A count of 32 sets `frame_lock`=1 and `wide_frame`=0. A count of 64 sets `frame_lock`=1 and `wide_frame`=1. Any other count sets `frame_lock`=0 and leaves `wide_frame` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_clk | input | 1 | Serial bit clock from the master |
| frame_clk | input | 1 | Frame clock, 1 = left half, 0 = right half |
| ser_din | input | 1 | Serial data input |
| ser_dout | output | 1 | Serial data output |
| rx_left | output | 16 | Last received left word |
| rx_right | output | 16 | Last received right word |
| rx_valid | output | 1 | One-cycle pulse when a new received pair is ready |
| tx_left | input | 16 | Left word to send |
| tx_right | input | 16 | Right word to send |
| tx_valid | input | 1 | Transmit pair offered |
| tx_ready | output | 1 | Pending slot is empty |
| frame_lock | output | 1 | Last frame had a recognised length |
| wide_frame | output | 1 | Recognised framing is 64 bit clocks per frame |

## Verification
The bench uses the default two-stage pin synchroniser and the package's 16-bit sample width. It drives each bit period as sixteen system clock cycles, which leaves room for the synchroniser and edge detector delays before each sample point. Frames of 32, 48 and 64 bit clocks bring the narrow framing, the padded wide framing and the loss and recovery of lock into reach. Frames sent with and without a pending pair, and words at both extremes of the signed range, exercise the zero-fill and handshake paths.

// File: rtl/asp_pkg.sv
package asp_pkg;

    localparam int SAMPLE_W    = 16;
    localparam int NARROW_BITS = 2 * SAMPLE_W;
    localparam int WIDE_BITS   = 4 * SAMPLE_W;
    localparam int POS_W       = $clog2(WIDE_BITS);
    localparam int FCNT_W      = $clog2(WIDE_BITS + 1) + 1;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef enum logic {
        FMT_NARROW = 1'b0,
        FMT_WIDE   = 1'b1
    } frame_fmt_e;

    typedef struct packed {
        sample_t left;
        sample_t right;
    } stereo_t;

    typedef struct packed {
        logic       ok;
        frame_fmt_e fmt;
    } fmt_result_t;

    function automatic fmt_result_t classify_frame(input logic [FCNT_W-1:0] n);
        fmt_result_t r;
        r.ok  = 1'b0;
        r.fmt = FMT_NARROW;
        if (n == FCNT_W'(NARROW_BITS)) begin
            r.ok  = 1'b1;
            r.fmt = FMT_NARROW;
        end else if (n == FCNT_W'(WIDE_BITS)) begin
            r.ok  = 1'b1;
            r.fmt = FMT_WIDE;
        end
        return r;
    endfunction

endpackage

// File: rtl/asp_sync.sv
module asp_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], din[i]};
            end
        end
        assign dout[i] = chain[STAGES-1];
    end

endmodule

// File: rtl/asp_rx.sv
module asp_rx
    import asp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    rise,
    input  logic    lrck,
    input  logic    sd,
    output sample_t rx_left,
    output sample_t rx_right,
    output logic    rx_valid
);

    localparam logic [POS_W-1:0] POS_MAX = '1;

    logic             lr_last;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] pos_n;
    sample_t          shreg;
    sample_t          sh_n;
    sample_t          left_hold;
    logic             got_left;
    logic             new_half;
    logic             in_data;
    logic             last_bit;

    always_comb begin
        new_half = (lrck != lr_last);
        if (new_half) begin
            pos_n = '0;
        end else if (pos == POS_MAX) begin
            pos_n = pos;
        end else begin
            pos_n = pos + 1'b1;
        end
        in_data  = (pos_n < POS_W'(SAMPLE_W));
        last_bit = (pos_n == POS_W'(SAMPLE_W - 1));
        sh_n     = {shreg[SAMPLE_W-2:0], sd};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lr_last   <= 1'b0;
            pos       <= POS_MAX;
            shreg     <= '0;
            left_hold <= '0;
            got_left  <= 1'b0;
            rx_left   <= '0;
            rx_right  <= '0;
            rx_valid  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (rise) begin
                lr_last <= lrck;
                pos     <= pos_n;
                if (in_data) begin
                    shreg <= sh_n;
                end
                if (last_bit) begin
                    if (lrck) begin
                        left_hold <= sh_n;
                        got_left  <= 1'b1;
                    end else if (got_left) begin
                        rx_left  <= left_hold;
                        rx_right <= sh_n;
                        rx_valid <= 1'b1;
                        got_left <= 1'b0;
                    end
                end
            end
        end
    end

    AST_RX_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R3

    AST_RX_WORDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> ($stable(rx_left) && $stable(rx_right))); // R3

endmodule

// File: rtl/asp_tx.sv
module asp_tx
    import asp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    fall,
    input  logic    lrck,
    input  logic    tx_valid,
    input  sample_t tx_left,
    input  sample_t tx_right,
    output logic    tx_ready,
    output logic    sdout
);

    localparam logic [POS_W-1:0] POS_MAX = '1;

    stereo_t          pend;
    logic             pend_full;
    stereo_t          next_pair;
    sample_t          cur_right;
    sample_t          shreg;
    logic             lr_last;
    logic [POS_W-1:0] tpos;
    logic             new_half;
    logic             left_start;
    logic             accept;

    assign tx_ready = ~pend_full;

    always_comb begin
        accept     = tx_valid & ~pend_full;
        new_half   = fall & (lrck != lr_last);
        left_start = new_half & lrck;
        next_pair  = pend_full ? pend : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= '0;
            pend_full <= 1'b0;
        end else begin
            if (left_start) begin
                pend_full <= 1'b0;
            end
            if (accept) begin
                pend.left  <= tx_left;
                pend.right <= tx_right;
                pend_full  <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_right <= '0;
            shreg     <= '0;
            lr_last   <= 1'b0;
            tpos      <= POS_MAX;
            sdout     <= 1'b0;
        end else if (fall) begin
            lr_last <= lrck;
            if (new_half) begin
                tpos <= '0;
                if (lrck) begin
                    cur_right <= next_pair.right;
                    sdout     <= next_pair.left[SAMPLE_W-1];
                    shreg     <= {next_pair.left[SAMPLE_W-2:0], 1'b0};
                end else begin
                    sdout <= cur_right[SAMPLE_W-1];
                    shreg <= {cur_right[SAMPLE_W-2:0], 1'b0};
                end
            end else begin
                sdout <= shreg[SAMPLE_W-1];
                shreg <= {shreg[SAMPLE_W-2:0], 1'b0};
                if (tpos != POS_MAX) begin
                    tpos <= tpos + 1'b1;
                end
            end
        end
    end

    AST_DOUT_ONLY_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        !fall |=> $stable(sdout)); // R5

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tpos >= POS_W'(SAMPLE_W)) |-> !sdout); // R6

    AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_ready); // R8

endmodule

// File: rtl/asp_fmt_detect.sv
module asp_fmt_detect
    import asp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic lrck,
    output logic frame_lock,
    output logic wide_frame
);

    localparam logic [FCNT_W-1:0] CNT_MAX = '1;

    logic              lr_last;
    logic [FCNT_W-1:0] cnt;
    fmt_result_t       res;

    always_comb begin
        res = classify_frame(cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lr_last    <= 1'b0;
            cnt        <= '0;
            frame_lock <= 1'b0;
            wide_frame <= 1'b0;
        end else if (rise) begin
            lr_last <= lrck;
            if (lrck && !lr_last) begin
                frame_lock <= res.ok;
                if (res.ok) begin
                    wide_frame <= (res.fmt == FMT_WIDE);
                end
                cnt <= FCNT_W'(1);
            end else if (cnt != CNT_MAX) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_LOCK_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        !rise |=> ($stable(frame_lock) && $stable(wide_frame))); // R9

endmodule

// File: rtl/serial_audio_port.sv
module serial_audio_port
    import asp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_clk,
    input  logic                frame_clk,
    input  logic                ser_din,
    output logic                ser_dout,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                rx_valid,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    input  logic                tx_valid,
    output logic                tx_ready,
    output logic                frame_lock,
    output logic                wide_frame
);

    localparam int PIN_N = 3;

    logic [PIN_N-1:0] pins_raw;
    logic [PIN_N-1:0] pins_s;
    logic             bclk_s;
    logic             fclk_s;
    logic             din_s;
    logic             bclk_q;
    logic             rise;
    logic             fall;

    assign pins_raw = {bit_clk, frame_clk, ser_din};

    asp_sync #(
        .WIDTH  (PIN_N),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pins_raw),
        .dout (pins_s)
    );

    assign bclk_s = pins_s[2];
    assign fclk_s = pins_s[1];
    assign din_s  = pins_s[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q <= 1'b0;
        end else begin
            bclk_q <= bclk_s;
        end
    end

    assign rise = bclk_s & ~bclk_q;
    assign fall = ~bclk_s & bclk_q;

    asp_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .rise     (rise),
        .lrck     (fclk_s),
        .sd       (din_s),
        .rx_left  (rx_left),
        .rx_right (rx_right),
        .rx_valid (rx_valid)
    );

    asp_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .fall     (fall),
        .lrck     (fclk_s),
        .tx_valid (tx_valid),
        .tx_left  (tx_left),
        .tx_right (tx_right),
        .tx_ready (tx_ready),
        .sdout    (ser_dout)
    );

    asp_fmt_detect u_fmt (
        .clk        (clk),
        .rst        (rst),
        .rise       (rise),
        .lrck       (fclk_s),
        .frame_lock (frame_lock),
        .wide_frame (wide_frame)
    );

endmodule

// File: tb/tb_serial_audio_port.sv
module tb_serial_audio_port;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 8;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk = 1'b1;
    logic        fclk = 1'b0;
    logic        din = 1'b0;
    logic        sdout;
    logic [15:0] rx_left;
    logic [15:0] rx_right;
    logic        rx_valid;
    logic [15:0] tx_left = '0;
    logic [15:0] tx_right = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic        frame_lock;
    logic        wide_frame;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    logic [15:0] exp_l[$];
    logic [15:0] exp_r[$];
    string       rx_tag = "R2";
    bit          prev_valid = 0;

    bit          m_pend = 0;
    logic [15:0] m_pl = '0;
    logic [15:0] m_pr = '0;
    logic [15:0] m_cur_l = '0;
    logic [15:0] m_cur_r = '0;
    int          prev_len = 0;
    bit          m_lock = 0;
    bit          m_wide = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_audio_port dut (
        .clk        (clk),
        .rst        (rst),
        .bit_clk    (bclk),
        .frame_clk  (fclk),
        .ser_din    (din),
        .ser_dout   (sdout),
        .rx_left    (rx_left),
        .rx_right   (rx_right),
        .rx_valid   (rx_valid),
        .tx_left    (tx_left),
        .tx_right   (tx_right),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .frame_lock (frame_lock),
        .wide_frame (wide_frame)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic waitn(int n);
        repeat (n) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                if (exp_l.size() == 0) begin
                    check(1'b0, "R3 unexpected rx_valid", 1, 0);
                end else begin
                    logic [15:0] el;
                    logic [15:0] er;
                    el = exp_l.pop_front();
                    er = exp_r.pop_front();
                    check(rx_left == el, rx_tag, int'(rx_left), int'(el));
                    check(rx_right == er, rx_tag, int'(rx_right), int'(er));
                end
                check(!prev_valid, "R3 pulse width", 1, 0);
            end
            prev_valid = rx_valid;
        end
    end

    task automatic offer_tx(logic [15:0] l, logic [15:0] r);
        check(tx_ready == 1'b1, "R8 ready before offer", int'(tx_ready), 1);
        tx_valid = 1'b1;
        tx_left  = l;
        tx_right = r;
        waitn(1);
        tx_valid = 1'b0;
        tx_left  = 16'h5a5a;
        tx_right = 16'ha5a5;
        waitn(1);
        check(tx_ready == 1'b0, "R8 ready after accept", int'(tx_ready), 0);
        m_pend = 1;
        m_pl   = l;
        m_pr   = r;
    endtask

    task automatic run_frame(int half, logic [15:0] l, logic [15:0] r);
        logic [15:0] word_out;
        logic [15:0] word_in;
        bit          empty;
        bit          had;
        logic        exp_bit;
        string       tag;
        empty = 0;
        had   = m_pend;
        exp_l.push_back(l);
        exp_r.push_back(r);
        rx_tag = (half > 16) ? "R4" : "R2";
        if (prev_len == 32) begin
            m_lock = 1; m_wide = 0;
        end else if (prev_len == 64) begin
            m_lock = 1; m_wide = 1;
        end else begin
            m_lock = 0;
        end
        for (int h = 0; h < 2; h++) begin
            for (int b = 0; b < half; b++) begin
                bclk = 1'b0;
                if (b == 0) fclk = (h == 0);
                if (h == 0 && b == 0) begin
                    empty   = !m_pend;
                    m_cur_l = m_pend ? m_pl : 16'h0;
                    m_cur_r = m_pend ? m_pr : 16'h0;
                    m_pend  = 0;
                end
                word_out = (h == 0) ? m_cur_l : m_cur_r;
                word_in  = (h == 0) ? l : r;
                if (b < 16) din = word_in[15-b];
                else        din = ((b % 2) != h);
                exp_bit = (b < 16) ? word_out[15-b] : 1'b0;
                tag = (b >= 16) ? "R6" : (empty ? "R7" : "R5");
                waitn(HALF_BIT);
                check(sdout === exp_bit, tag, int'(sdout), int'(exp_bit));
                if (h == 0 && b == 1) begin
                    check(frame_lock == m_lock, "R9 lock", int'(frame_lock), int'(m_lock));
                    check(wide_frame == m_wide, "R9 wide", int'(wide_frame), int'(m_wide));
                end
                bclk = 1'b1;
                waitn(HALF_BIT);
            end
        end
        prev_len = 2 * half;
        waitn(4);
        check(exp_l.size() == 0, "R3 pair delivered", exp_l.size(), 0);
        if (had) check(tx_ready == 1'b1, "R8 ready after latch", int'(tx_ready), 1);
    endtask

    initial begin
        waitn(6);
        rst = 1'b0;
        waitn(1);
        check(sdout == 1'b0, "R1 sdout", int'(sdout), 0);
        check(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
        check(tx_ready == 1'b1, "R1 tx_ready", int'(tx_ready), 1);
        check(frame_lock == 1'b0, "R1 frame_lock", int'(frame_lock), 0);
        waitn(8);

        run_frame(32, 16'h1234, 16'habcd);
        offer_tx(16'hc3a5, 16'h0ff1);
        run_frame(32, 16'h8000, 16'h7fff);
        offer_tx(16'h8001, 16'h7ffe);
        run_frame(16, 16'hffff, 16'h0001);
        run_frame(16, 16'h0000, 16'h8000);
        offer_tx(16'h9669, 16'h3cc3);
        run_frame(24, 16'h2468, 16'hfedc);
        run_frame(16, 16'h1357, 16'h9bdf);
        offer_tx(16'h8000, 16'h7fff);
        run_frame(16, 16'haaaa, 16'h5555);
        offer_tx(16'h7fff, 16'h8000);
        run_frame(32, 16'h0f0f, 16'hf0f0);
        run_frame(16, 16'h4321, 16'hdcba);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule